// File: doc/BRIEF.md
# Resistive Touch Panel Conversion Sequencer

This block runs one measurement pass of a 4-wire resistive touch panel on each trigger, using a single converter that sits outside the block. The converter is driven through a start/done handshake and returns a 10-bit sample. The block drives four switch-enable outputs. One pair biases the panel along the X axis and the other along the Y axis. Each switch pair stays closed for a programmable settle window before a conversion starts. For each axis the block takes an offset sample first, then two position samples. It subtracts the offset from each position sample.

After the panel steps, the auxiliary channels 4 and 5 are converted if the user has enabled them. Outside touch mode the block converts the enabled channels 0 to 5 in ascending order, at 8-bit or 10-bit resolution. Each result goes to its own channel register and to a last-result register. When streaming is on, each result is also emitted as one zero-extended 16-bit word, so a DMA engine can pack the results into a buffer without gaps. A sleep option powers the converter up at the start of every pass, waits a programmable startup time, and powers it down again at the end of the pass.

Top module: `tpanel_seq`

## Requirements
- R1: With `ts_mode`=1, bits 0..3 of `chan_status` read 1 whatever `ch_en` holds. Bits 4..5 always mirror `ch_en`. With `ts_mode`=0, `chan_status` equals `ch_en`.
- R2: With `ts_mode`=1, every result is the full 10-bit sample and `low_res` has no effect.
- R3: With `sleep_en`=1, `adc_pwr` is 0 while idle and 1 for the whole pass. The first start comes `startup_cyc`+1 cycles of wake-up plus `hold_cyc`+1 cycles of settle after the trigger is sampled. With `sleep_en`=0, `adc_pwr` stays 1.
- R4: Every conversion is preceded by a settle window of exactly `hold_cyc`+1 cycles. The window is counted from the cycle that samples the trigger (no sleep) or the previous `adc_done`. `adc_start` is a single-cycle pulse.
- R5: In touch mode the three X steps run first with only `sw_xp`/`sw_xm` closed, then the three Y steps with only `sw_yp`/`sw_ym` closed. No switch is closed during the auxiliary conversions or while idle.
- R6: Within an axis, the first sample is an offset held in channel 1 (X) or channel 3 (Y). The second sample minus the offset goes to channel 0 (X) or channel 2 (Y). The third sample minus the offset goes to channel 1 (X) or channel 3 (Y). A negative difference becomes 0. Each difference is also written to `last_data`.
- R7: In touch mode, channels 4 and 5 are converted after the Y axis, each one only if its `ch_en` bit is set. The result goes to the channel register and to `last_data`.
- R8: With `stream_en`=1, each non-offset result is emitted in pass order as a one-cycle `stream_valid` with `stream_word` = result zero-extended to 16 bits. Offsets are never emitted. With `stream_en`=0 nothing is emitted, but the registers still update.
- R9: With `ts_mode`=0, the enabled channels are converted in ascending order. With `low_res`=1 each result is the top 8 bits of the sample; with `low_res`=0 it is the full 10 bits.
- R10: A trigger during a pass is ignored, and `overrun` pulses the next cycle. A trigger when no step is active starts nothing.
- R11: After reset the block is idle, all switches are open, no start or stream pulse is active, and all channel registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig | input | 1 | Starts a pass |
| ts_mode | input | 1 | Touch panel mode |
| low_res | input | 1 | 8-bit results outside touch mode |
| sleep_en | input | 1 | Power converter only during a pass |
| stream_en | input | 1 | Enable the streamed result words |
| ch_en | input | 6 | User channel enables |
| startup_cyc | input | 8 | Wake-up wait, value+1 cycles |
| hold_cyc | input | 8 | Settle window, value+1 cycles |
| adc_start | output | 1 | Converter start pulse |
| adc_done | input | 1 | Converter result valid |
| adc_data | input | 10 | Converter sample |
| adc_pwr | output | 1 | Converter power enable |
| sw_xp | output | 1 | X+ switch enable |
| sw_xm | output | 1 | X- switch enable |
| sw_yp | output | 1 | Y+ switch enable |
| sw_ym | output | 1 | Y- switch enable |
| busy | output | 1 | Pass in progress |
| overrun | output | 1 | Trigger dropped while busy |
| chan_status | output | 6 | Effective channel enables |
| ch_data | output | 60 | Channel registers, channel n at bits 10n+9..10n |
| last_data | output | 10 | Last stored result |
| stream_valid | output | 1 | Stream word valid |
| stream_word | output | 16 | Streamed result |

## Verification
The touch pass is run with samples below and above the offset. This separates a correct saturating subtraction from a wrapped one, and it shows which register receives each difference. The same pass is run with `low_res` set, to show that the setting is ignored in touch mode. A second touch pass uses sleep and a zero settle time. It separates the wake-up wait from the settle window by measuring the gap between the trigger and the first start, then between each done and the next start. Scan-mode passes with scattered enables, at both resolutions and with streaming on and off, separate channel ordering, truncation and emission. A trigger during a pass and a trigger with nothing enabled expose any restart or phantom pass.

// File: rtl/tpanel_seq.sv
module tpanel_seq #(
  parameter int DW = 10,
  parameter int LW = 8,
  parameter int TW = 8,
  parameter int OW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic             ts_mode,
  input  logic             low_res,
  input  logic             sleep_en,
  input  logic             stream_en,
  input  logic [5:0]       ch_en,
  input  logic [TW-1:0]    startup_cyc,
  input  logic [TW-1:0]    hold_cyc,
  output logic             adc_start,
  input  logic             adc_done,
  input  logic [DW-1:0]    adc_data,
  output logic             adc_pwr,
  output logic             sw_xp,
  output logic             sw_xm,
  output logic             sw_yp,
  output logic             sw_ym,
  output logic             busy,
  output logic             overrun,
  output logic [5:0]       chan_status,
  output logic [6*DW-1:0]  ch_data,
  output logic [DW-1:0]    last_data,
  output logic             stream_valid,
  output logic [OW-1:0]    stream_word
);
  localparam int NCH = 6;
  localparam int NPS = 6;
  localparam int NST = NPS + NCH;
  localparam int SW  = $clog2(NST + 1);
  localparam logic [SW-1:0] NONE = SW'(NST);

  typedef enum logic [2:0] {S_IDLE, S_WAKE, S_HOLD, S_START, S_WAIT} st_t;

  st_t            st;
  logic [SW-1:0]  step;
  logic [TW-1:0]  cnt;
  logic [DW-1:0]  chq [NCH];
  logic [NST-1:0] act;
  logic [SW-1:0]  first, nxt;
  logic           panel, yaxis, settle;
  logic [SW-1:0]  pos;
  logic [2:0]     offs_i, widx;
  logic [DW-1:0]  offs, diff, res, val;

  function automatic logic [SW-1:0] find(input logic [NST-1:0] a, input logic [SW-1:0] from);
    find = NONE;
    for (int k = NST - 1; k >= 0; k--)
      if (k >= int'(from) && a[k]) find = SW'(k);
  endfunction

  assign act   = {ts_mode ? (ch_en & 6'b110000) : ch_en, {NPS{ts_mode}}};
  assign first = find(act, '0);
  assign nxt   = find(act, step + 1'b1);

  assign panel  = step < SW'(NPS);
  assign yaxis  = step >= SW'(3);
  assign pos    = yaxis ? step - SW'(3) : step;
  assign offs_i = yaxis ? 3'd3 : 3'd1;
  assign widx   = !panel ? 3'(step - SW'(NPS)) : (pos == SW'(1)) ? offs_i - 3'd1 : offs_i;
  assign offs   = chq[offs_i];
  assign diff   = (adc_data >= offs) ? adc_data - offs : '0;
  assign res    = (ts_mode || !low_res) ? adc_data : DW'(adc_data[DW-1 -: LW]);
  assign val    = panel ? diff : res;

  assign busy     = st != S_IDLE;
  assign settle   = st == S_HOLD || st == S_START || st == S_WAIT;
  assign sw_xp    = settle && panel && !yaxis;
  assign sw_xm    = sw_xp;
  assign sw_yp    = settle && panel && yaxis;
  assign sw_ym    = sw_yp;
  assign adc_start = st == S_START;
  assign adc_pwr   = !sleep_en || busy;
  assign chan_status = ts_mode ? (ch_en | 6'b001111) : ch_en;

  for (genvar g = 0; g < NCH; g++) begin : g_out
    assign ch_data[g*DW +: DW] = chq[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      step         <= '0;
      cnt          <= '0;
      last_data    <= '0;
      overrun      <= 1'b0;
      stream_valid <= 1'b0;
      stream_word  <= '0;
      for (int i = 0; i < NCH; i++) chq[i] <= '0;
    end else begin
      stream_valid <= 1'b0;
      overrun      <= trig && busy;
      case (st)
        S_IDLE: if (trig && first != NONE) begin
          step <= first;
          st   <= sleep_en ? S_WAKE : S_HOLD;
          cnt  <= sleep_en ? startup_cyc : hold_cyc;
        end
        S_WAKE: if (cnt == '0) begin
          st  <= S_HOLD;
          cnt <= hold_cyc;
        end else cnt <= cnt - 1'b1;
        S_HOLD: if (cnt == '0) st <= S_START;
                else cnt <= cnt - 1'b1;
        S_START: st <= S_WAIT;
        S_WAIT: if (adc_done) begin
          if (panel && pos == '0) chq[offs_i] <= adc_data;
          else begin
            chq[widx] <= val;
            last_data <= val;
            if (stream_en) begin
              stream_valid <= 1'b1;
              stream_word  <= OW'(val);
            end
          end
          if (nxt == NONE) st <= S_IDLE;
          else begin
            step <= nxt;
            st   <= S_HOLD;
            cnt  <= hold_cyc;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tpanel_seq_chk.sv
module tpanel_seq_chk #(parameter int DW = 10, parameter int OW = 16) (
  input logic          clk,
  input logic          rst_n,
  input logic          adc_start,
  input logic          adc_pwr,
  input logic          sw_xp,
  input logic          sw_xm,
  input logic          sw_yp,
  input logic          sw_ym,
  input logic          busy,
  input logic          overrun,
  input logic          stream_valid,
  input logic [OW-1:0] stream_word
);
  AST_AXIS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !((sw_xp || sw_xm) && (sw_yp || sw_ym))); // R5
  AST_SWITCH_IDLE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(sw_xp || sw_xm || sw_yp || sw_ym)); // R5
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start); // R4
  AST_START_IN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> busy); // R4
  AST_POWER_IN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> adc_pwr); // R3
  AST_OVERRUN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> $past(busy)); // R10
  AST_STREAM_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    stream_valid |-> stream_word[OW-1:DW] == '0); // R8
endmodule

bind tpanel_seq tpanel_seq_chk #(.DW(DW), .OW(OW)) u_chk (
  .clk(clk), .rst_n(rst_n), .adc_start(adc_start), .adc_pwr(adc_pwr),
  .sw_xp(sw_xp), .sw_xm(sw_xm), .sw_yp(sw_yp), .sw_ym(sw_ym),
  .busy(busy), .overrun(overrun), .stream_valid(stream_valid),
  .stream_word(stream_word));

// File: tb/tpanel_seq_test.sv
module tpanel_seq_test;
  logic        clk = 0, rst_n = 0, trig = 0;
  logic        ts_mode = 0, low_res = 0, sleep_en = 0, stream_en = 1;
  logic [5:0]  ch_en = 0;
  logic [7:0]  startup_cyc = 0, hold_cyc = 0;
  logic        adc_start, adc_done = 0, adc_pwr;
  logic [9:0]  adc_data = 0;
  logic        sw_xp, sw_xm, sw_yp, sw_ym, busy, overrun, stream_valid;
  logic [5:0]  chan_status;
  logic [59:0] ch_data;
  logic [9:0]  last_data;
  logic [15:0] stream_word;

  tpanel_seq uut (.*);

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  int samp[32];
  int sidx, lat, nstrm, nconv, gap;
  int strm[32], swlog[16], gaps[16];
  bit pwr_ok, ovr_seen, req;

  always @(negedge clk) begin
    if (stream_valid && nstrm < 32) begin strm[nstrm] = stream_word; nstrm++; end
    if (overrun) ovr_seen = 1;
    if (adc_start) begin
      if (nconv < 16) begin swlog[nconv] = {sw_xp, sw_xm, sw_yp, sw_ym}; gaps[nconv] = gap; end
      if (!adc_pwr) pwr_ok = 0;
      nconv++;
      gap = 0;
    end else gap++;
    adc_done = 0;
    if (lat > 0) begin
      lat--;
      if (lat == 0) begin adc_done = 1; adc_data = 10'(samp[sidx % 32]); sidx++; gap = 0; end
    end
    if (adc_start) lat = 2;
    trig = 0;
    if (req) begin trig = 1; req = 0; gap = 0; end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int chv(int i);
    return int'(ch_data[i*10 +: 10]);
  endfunction

  task automatic clear();
    sidx = 0; nstrm = 0; nconv = 0; pwr_ok = 1; ovr_seen = 0;
  endtask

  task automatic run_seq();
    clear();
    @(posedge clk); req = 1;
    repeat (3) @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(!busy && !sw_xp && !sw_yp && !adc_start && !stream_valid && !overrun, "R11 idle outputs", busy, 0);
    chk(ch_data == 0, "R11 channel regs", int'(ch_data[31:0]), 0);
  endtask

  task automatic t_touch();
    int exp_s[5] = '{300, 250, 0, 700, 123};
    ts_mode = 1; low_res = 1; sleep_en = 0; stream_en = 1; ch_en = 6'b010000; hold_cyc = 2;
    samp[0:6] = '{100, 400, 350, 200, 50, 900, 123};
    @(negedge clk);
    chk(chan_status == 6'b011111, "R1 status forced", chan_status, 31);
    run_seq();
    chk(nconv == 7, "R7 only enabled aux converted", nconv, 7);
    for (int i = 0; i < 7; i++) begin
      int e = (i < 3) ? 12 : (i < 6) ? 3 : 0;
      chk(swlog[i] == e, "R5 switch pair at start", swlog[i], e);
      chk(gaps[i] == 3, "R4 settle window", gaps[i], 3);
    end
    chk(chv(0) == 300 && chv(1) == 250, "R6 X differences", chv(0), 300);
    chk(chv(2) == 0, "R6 saturation", chv(2), 0);
    chk(chv(3) == 700, "R6 Y difference", chv(3), 700);
    chk(chv(4) == 123 && chv(5) == 0, "R7 aux register", chv(4), 123);
    chk(last_data == 123, "R7 last data", last_data, 123);
    chk(nstrm == 5, "R8 stream count", nstrm, 5);
    for (int i = 0; i < 5; i++) chk(strm[i] == exp_s[i], "R8 R2 stream word", strm[i], exp_s[i]);
    chk(!ovr_seen, "R10 no overrun when idle", ovr_seen, 0);
    chk(adc_pwr, "R3 power without sleep", adc_pwr, 1);
  endtask

  task automatic t_sleep();
    ts_mode = 1; sleep_en = 1; startup_cyc = 4; hold_cyc = 0; ch_en = 0; low_res = 0;
    samp[0:5] = '{10, 20, 30, 40, 50, 60};
    @(negedge clk);
    chk(!adc_pwr, "R3 power off idle", adc_pwr, 0);
    run_seq();
    chk(nconv == 6, "R3 conversion count", nconv, 6);
    chk(gaps[0] == 6, "R3 wake plus settle", gaps[0], 6);
    chk(gaps[1] == 1 && gaps[5] == 1, "R4 zero settle", gaps[1], 1);
    chk(pwr_ok, "R3 powered in pass", pwr_ok, 1);
    chk(!adc_pwr, "R3 power off after", adc_pwr, 0);
    chk(chv(0) == 10 && chv(1) == 20 && chv(2) == 10 && chv(3) == 20, "R6 registers", chv(3), 20);
    chk(nstrm == 4 && strm[0] == 10 && strm[3] == 20, "R8 offsets not streamed", nstrm, 4);
    sleep_en = 0;
  endtask

  task automatic t_scan();
    ts_mode = 0; low_res = 1; ch_en = 6'b100101; hold_cyc = 1; stream_en = 1;
    samp[0:2] = '{1023, 341, 512};
    @(negedge clk);
    chk(chan_status == 6'b100101, "R1 status mirror", chan_status, 37);
    run_seq();
    chk(nconv == 3, "R9 enabled count", nconv, 3);
    chk(swlog[0] == 0 && swlog[2] == 0, "R5 no switch in scan", swlog[0], 0);
    chk(gaps[1] == 2, "R4 settle scan", gaps[1], 2);
    chk(chv(0) == 255 && chv(2) == 85 && chv(5) == 128, "R9 low res order", chv(2), 85);
    chk(nstrm == 3 && strm[2] == 128, "R8 scan stream", strm[2], 128);
    low_res = 0; ch_en = 6'b000010; samp[0] = 683;
    run_seq();
    chk(chv(1) == 683 && last_data == 683, "R9 full res", chv(1), 683);
    chk(nstrm == 1 && strm[0] == 683, "R8 full res word", strm[0], 683);
  endtask

  task automatic t_nostream();
    ts_mode = 0; low_res = 1; ch_en = 6'b100101; stream_en = 0;
    samp[0:2] = '{4, 8, 12};
    run_seq();
    chk(nstrm == 0, "R8 stream disabled", nstrm, 0);
    chk(chv(0) == 1 && chv(2) == 2 && chv(5) == 3, "R8 regs still update", chv(5), 3);
    stream_en = 1;
  endtask

  task automatic t_overrun();
    ts_mode = 0; low_res = 0; ch_en = 6'b000111; hold_cyc = 3;
    samp[0:2] = '{5, 6, 7};
    clear();
    @(posedge clk); req = 1;
    repeat (6) @(negedge clk);
    @(posedge clk); req = 1;
    repeat (3) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(ovr_seen, "R10 overrun flagged", ovr_seen, 1);
    chk(nconv == 3 && nstrm == 3, "R10 no restart", nconv, 3);
    ch_en = 0;
    run_seq();
    chk(nconv == 0 && !busy, "R10 empty trigger", nconv, 0);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_touch();
    t_sleep();
    t_scan();
    t_nostream();
    t_overrun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule